// File: doc/BRIEF.md
# Flash Access Protection Gate

This block sits in front of a serial-flash cycle sequencer and rules on every cycle before any traffic starts. A requester presents a 24-bit flash address and a flag that says whether the opcode writes or erases. One clock later the gate answers with either a grant or a refusal. A refused cycle produces no flash traffic. Instead, the refusal is latched in a sticky status bit so that software can find it later.

Two mechanisms protect the flash. The first is a lower-bound fence register: any access, read or write, to an address below the fence is refused. The second is three window registers. Each window has its own enable, and each covers a span of 4 KiB pages given by a first page and a last page. A write or erase whose address falls in any enabled window is refused. Reads pass through the windows unchecked.

A configuration lock bit completes the set. Once software sets it, the opcode menu, the opcode type table, the prefix table, the fence and the windows ignore writes until the next reset. The write-1-to-clear status bits stay usable while the lock is set.

Top module: `flash_guard`

## Requirements
- R1: After a synchronous active-low reset, every configuration register reads 0, the status register reads 0, and `rsp_valid`, `rsp_grant` and `rsp_blocked` are low.
- R2: A request whose address is strictly below the fence value (register select 1, bits 23:0) is refused whatever its type. A request at or above the fence is not refused by the fence.
- R3: A window register (selects 6, 7, 8) has bit 31 as enable, bits 23:12 as the last page and bits 11:0 as the first page. A write request is refused when the address page (bits 23:12) is between the first and last page inclusive. This covers the whole last 4 KiB page. The page just below the window and the page just above it are granted.
- R4: A window whose bit 31 is clear refuses nothing.
- R5: A read request (`req_wr` = 0) is never refused by a window.
- R6: The three windows act independently. A write is refused when it hits any enabled window.
- R7: Each request cycle yields exactly one response cycle on the next clock. In that cycle exactly one of `rsp_grant` and `rsp_blocked` is high. With no request, the next cycle has no response.
- R8: A refusal sets status bit 3 and a grant sets status bit 2 (status is select 0). Writing 1 to either bit clears it. A set in the same cycle as a clear wins.
- R9: Writing status bit 15 as 1 sets the lock. Writing it as 0 has no effect. Only reset clears the lock.
- R10: While locked, writes to the fence, the type table (select 2), the opcode menu (selects 3 and 4), the prefix table (select 5) and the windows are dropped, and their read-back is unchanged. Protection keeps working, and status bits 3 and 2 can still be cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select for writes |
| cfg_wdata | input | 32 | Register write data |
| cfg_rsel | input | 4 | Register select for read-back |
| cfg_rdata | output | 32 | Read-back data (combinational) |
| req_valid | input | 1 | Flash cycle request |
| req_addr | input | 24 | Flash byte address of the cycle |
| req_wr | input | 1 | Cycle is a write or erase |
| rsp_valid | output | 1 | Decision available (one clock after request) |
| rsp_grant | output | 1 | Cycle may start |
| rsp_blocked | output | 1 | Cycle refused |

## Verification
The bench probes both ends of a window: the first byte of the first page, the last byte of the last page, and the bytes just outside each end. A design that treated the limit as a byte address, or compared with strict inequality, would grant the last page or refuse its neighbour. The fence is probed one byte below and exactly at its value, which exposes an off-by-one that refuses the fence address itself. The lock is tested by writing 0 to it after it is set, and by attempted writes to every frozen register. A design that let the lock clear, or that failed to freeze one table, would show a changed read-back. A design that froze the status clear bits too would leave bit 3 stuck.

// File: rtl/flash_guard_pkg.sv
// Package: shared widths, register selects and status bit positions
// for the flash access protection gate.
package flash_guard_pkg;
    localparam int ADDR_W   = 24;             // flash byte address width
    localparam int PAGE_LSB = 12;             // 4 KiB page granularity
    localparam int PG_W     = ADDR_W - PAGE_LSB;
    localparam int SEL_W    = 4;
    localparam int DATA_W   = 32;

    localparam logic [SEL_W-1:0] SEL_STATUS  = 4'd0;
    localparam logic [SEL_W-1:0] SEL_FENCE   = 4'd1;
    localparam logic [SEL_W-1:0] SEL_TYPES   = 4'd2;
    localparam logic [SEL_W-1:0] SEL_MENU_LO = 4'd3;
    localparam logic [SEL_W-1:0] SEL_MENU_HI = 4'd4;
    localparam logic [SEL_W-1:0] SEL_PREFIX  = 4'd5;
    localparam logic [SEL_W-1:0] SEL_WIN0    = 4'd6;

    localparam int LOCK_BIT   = 15;
    localparam int BLK_BIT    = 3;
    localparam int DONE_BIT   = 2;
    localparam int WIN_EN_BIT = 31;
endpackage

// File: rtl/fg_window.sv
// fg_window: one write-protect window compare.
// Assumes first/last page fields are already extracted from the register;
// hit is purely combinational and qualified by the window enable.
module fg_window
    import flash_guard_pkg::*;
(
    input  logic            en,
    input  logic [PG_W-1:0] first_pg,
    input  logic [PG_W-1:0] last_pg,
    input  logic [PG_W-1:0] addr_pg,
    output logic            hit
);
    // Inclusive page-range membership test.
    always_comb begin
        hit = en && (addr_pg >= first_pg) && (addr_pg <= last_pg);
    end
endmodule

// File: rtl/fg_cfg_regs.sv
// fg_cfg_regs: configuration and status registers of the gate.
// Holds the lock, sticky status bits, fence, opcode tables and windows.
// Assumes at most one write per cycle; status events come from the
// decision logic in the same cycle the decision is registered.
module fg_cfg_regs
    import flash_guard_pkg::*;
#(
    parameter int NUM_WIN = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [SEL_W-1:0]           cfg_sel,
    input  logic [DATA_W-1:0]          cfg_wdata,
    input  logic [SEL_W-1:0]           cfg_rsel,
    output logic [DATA_W-1:0]          cfg_rdata,
    input  logic                       ev_grant,
    input  logic                       ev_block,
    output logic                       lock_o,
    output logic [ADDR_W-1:0]          fence_o,
    output logic [NUM_WIN-1:0]         win_en_o,
    output logic [NUM_WIN-1:0][PG_W-1:0] win_first_o,
    output logic [NUM_WIN-1:0][PG_W-1:0] win_last_o
);
    localparam int TBL_W = 16;

    logic                          lock_q;
    logic                          blk_q;
    logic                          done_q;
    logic [DATA_W-1:0]             fence_q;
    logic [TBL_W-1:0]              types_q;
    logic [DATA_W-1:0]             menu_lo_q;
    logic [DATA_W-1:0]             menu_hi_q;
    logic [TBL_W-1:0]              prefix_q;
    logic [NUM_WIN-1:0][DATA_W-1:0] win_q;

    logic sts_wr;
    logic cfg_wr;

    // Decode: status writes always allowed, config writes only when unlocked.
    always_comb begin
        sts_wr = cfg_we && (cfg_sel == SEL_STATUS);
        cfg_wr = cfg_we && !lock_q;
    end

    // Lock bit: set-only by software, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_q <= 1'b0;
        else if (sts_wr && cfg_wdata[LOCK_BIT])
            lock_q <= 1'b1;
    end

    // Sticky status bits: event set wins over write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (ev_block)
                blk_q <= 1'b1;
            else if (sts_wr && cfg_wdata[BLK_BIT])
                blk_q <= 1'b0;
            if (ev_grant)
                done_q <= 1'b1;
            else if (sts_wr && cfg_wdata[DONE_BIT])
                done_q <= 1'b0;
        end
    end

    // Lockable scalar configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fence_q   <= '0;
            types_q   <= '0;
            menu_lo_q <= '0;
            menu_hi_q <= '0;
            prefix_q  <= '0;
        end else if (cfg_wr) begin
            case (cfg_sel)
                SEL_FENCE:   fence_q   <= cfg_wdata;
                SEL_TYPES:   types_q   <= cfg_wdata[TBL_W-1:0];
                SEL_MENU_LO: menu_lo_q <= cfg_wdata;
                SEL_MENU_HI: menu_hi_q <= cfg_wdata;
                SEL_PREFIX:  prefix_q  <= cfg_wdata[TBL_W-1:0];
                default: ;
            endcase
        end
    end

    // Lockable window registers, one per generated slot.
    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        localparam logic [SEL_W-1:0] MY_SEL = SEL_WIN0 + SEL_W'(i);
        always_ff @(posedge clk) begin
            if (!rst_n)
                win_q[i] <= '0;
            else if (cfg_wr && (cfg_sel == MY_SEL))
                win_q[i] <= cfg_wdata;
        end
        assign win_en_o[i]    = win_q[i][WIN_EN_BIT];
        assign win_first_o[i] = win_q[i][PG_W-1:0];
        assign win_last_o[i]  = win_q[i][2*PG_W-1:PG_W];
    end

    // Read-back multiplexer.
    always_comb begin
        cfg_rdata = '0;
        case (cfg_rsel)
            SEL_STATUS: begin
                cfg_rdata[LOCK_BIT] = lock_q;
                cfg_rdata[BLK_BIT]  = blk_q;
                cfg_rdata[DONE_BIT] = done_q;
            end
            SEL_FENCE:   cfg_rdata = fence_q;
            SEL_TYPES:   cfg_rdata[TBL_W-1:0] = types_q;
            SEL_MENU_LO: cfg_rdata = menu_lo_q;
            SEL_MENU_HI: cfg_rdata = menu_hi_q;
            SEL_PREFIX:  cfg_rdata[TBL_W-1:0] = prefix_q;
            default: begin
                for (int k = 0; k < NUM_WIN; k++)
                    if (cfg_rsel == SEL_WIN0 + SEL_W'(k))
                        cfg_rdata = win_q[k];
            end
        endcase
    end

    assign lock_o  = lock_q;
    assign fence_o = fence_q[ADDR_W-1:0];
endmodule

// File: rtl/flash_guard.sv
// flash_guard: rules on each flash cycle before the sequencer starts it.
// Refuses any access below the fence and any write/erase inside an enabled
// window; the decision is registered and returned one clock after request.
// Assumes the requester holds no cycle open beyond the single request pulse.
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int NUM_WIN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [SEL_W-1:0]  cfg_rsel,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wr,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic              rsp_blocked
);
    logic                          lock_w;
    logic [ADDR_W-1:0]             fence_w;
    logic [NUM_WIN-1:0]            win_en;
    logic [NUM_WIN-1:0][PG_W-1:0]  win_first;
    logic [NUM_WIN-1:0][PG_W-1:0]  win_last;
    logic [NUM_WIN-1:0]            win_hit;
    logic                          refuse;
    logic                          ev_grant;
    logic                          ev_block;

    fg_cfg_regs #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .cfg_rsel   (cfg_rsel),
        .cfg_rdata  (cfg_rdata),
        .ev_grant   (ev_grant),
        .ev_block   (ev_block),
        .lock_o     (lock_w),
        .fence_o    (fence_w),
        .win_en_o   (win_en),
        .win_first_o(win_first),
        .win_last_o (win_last)
    );

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
        fg_window u_win (
            .en      (win_en[i]),
            .first_pg(win_first[i]),
            .last_pg (win_last[i]),
            .addr_pg (req_addr[ADDR_W-1:PAGE_LSB]),
            .hit     (win_hit[i])
        );
    end

    // Combine fence and window results into one refusal decision.
    always_comb begin
        refuse   = (req_addr < fence_w) || (req_wr && (|win_hit));
        ev_block = req_valid && refuse;
        ev_grant = req_valid && !refuse;
    end

    // Register the decision for the one-cycle response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_grant   <= 1'b0;
            rsp_blocked <= 1'b0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_grant   <= ev_grant;
            rsp_blocked <= ev_block;
        end
    end
endmodule

// File: rtl/flash_guard_chk.sv
// flash_guard_chk: temporal checks on the gate, bound into flash_guard.
// Assumes it sees the lock and fence values produced by the register block.
module flash_guard_chk
    import flash_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              rsp_valid,
    input  logic              rsp_grant,
    input  logic              rsp_blocked,
    input  logic              lock,
    input  logic [ADDR_W-1:0] fence
);
    a_r7_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r7_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_grant ^ rsp_blocked));
    a_r7_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_grant || rsp_blocked));
    a_r2_fence_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_addr < fence)) |=> rsp_blocked);
    a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);
    a_r10_fence_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && cfg_we && (cfg_sel == SEL_FENCE)) |=> $stable(fence));
endmodule

bind flash_guard flash_guard_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_grant  (rsp_grant),
    .rsp_blocked(rsp_blocked),
    .lock       (lock_w),
    .fence      (fence_w)
);

// File: tb/flash_guard_tb.sv
// flash_guard_tb: directed bench, one task per scenario, self-checking.
module flash_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [3:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic [3:0]  cfg_rsel;
    logic [31:0] cfg_rdata;
    logic        req_valid;
    logic [23:0] req_addr;
    logic        req_wr;
    logic        rsp_valid;
    logic        rsp_grant;
    logic        rsp_blocked;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    flash_guard u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_wr(req_wr),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_blocked(rsp_blocked)
    );

    // Compare one value and record the result.
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] sel, input logic [31:0] exp);
        cfg_rsel = sel;
        #1;
        chk(tag, cfg_rdata, exp);
    endtask

    // Issue one request and check the response on the following cycle.
    task automatic req(input string tag, input logic [23:0] a, input logic w, input logic exp_blk);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_wr = w;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R7 valid"}, {31'd0, rsp_valid}, 32'd1);
        chk({tag, " blocked"}, {30'd0, rsp_grant, rsp_blocked}, exp_blk ? 32'd1 : 32'd2);
        @(negedge clk);
        chk({tag, " R7 idle"}, {29'd0, rsp_valid, rsp_grant, rsp_blocked}, 32'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        chk("R1 rsp", {29'd0, rsp_valid, rsp_grant, rsp_blocked}, 32'd0);
        for (int s = 0; s < 9; s++)
            rd_chk($sformatf("R1 reg%0d", s), 4'(s), 32'd0);
    endtask

    task automatic t_fence();
        wr_reg(4'd1, 32'h0010_0000);
        req("R2 below fence read", 24'h0F_FFFF, 1'b0, 1'b1);
        req("R2 at fence read", 24'h10_0000, 1'b0, 1'b0);
        req("R2 below fence write", 24'h00_0000, 1'b1, 1'b1);
        rd_chk("R8 status set", 4'd0, 32'h0000_000C);
        wr_reg(4'd0, 32'h0000_0008);
        rd_chk("R8 clear blk", 4'd0, 32'h0000_0004);
        wr_reg(4'd0, 32'h0000_0004);
        rd_chk("R8 clear done", 4'd0, 32'h0000_0000);
        wr_reg(4'd1, 32'h0);
    endtask

    task automatic t_window();
        wr_reg(4'd6, 32'h8020_5200);
        rd_chk("R3 readback", 4'd6, 32'h8020_5200);
        req("R3 first byte", 24'h20_0000, 1'b1, 1'b1);
        req("R3 last byte", 24'h20_5FFF, 1'b1, 1'b1);
        req("R3 below", 24'h1F_FFFF, 1'b1, 1'b0);
        req("R3 above", 24'h20_6000, 1'b1, 1'b0);
        req("R5 read inside", 24'h20_3000, 1'b0, 1'b0);
    endtask

    task automatic t_independent();
        wr_reg(4'd7, 32'h0030_5300);
        req("R4 disabled window", 24'h30_3000, 1'b1, 1'b0);
        wr_reg(4'd8, 32'h8040_0400);
        req("R6 third window", 24'h40_0123, 1'b1, 1'b1);
        req("R6 past third", 24'h40_1000, 1'b1, 1'b0);
        req("R6 first still", 24'h20_1000, 1'b1, 1'b1);
        req("R4 still open", 24'h30_3000, 1'b1, 1'b0);
    endtask

    task automatic t_lock();
        wr_reg(4'd2, 32'h0000_1234);
        wr_reg(4'd3, 32'h0B03_0905);
        wr_reg(4'd5, 32'h0000_0650);
        wr_reg(4'd0, 32'h0000_000C);
        wr_reg(4'd0, 32'h0000_0000);
        rd_chk("R9 zero no lock", 4'd0, 32'h0);
        wr_reg(4'd0, 32'h0000_8000);
        rd_chk("R9 lock set", 4'd0, 32'h0000_8000);
        wr_reg(4'd0, 32'h0000_0000);
        rd_chk("R9 lock holds", 4'd0, 32'h0000_8000);
        wr_reg(4'd1, 32'h00FF_FFFF);
        rd_chk("R10 fence", 4'd1, 32'h0);
        wr_reg(4'd6, 32'h0);
        rd_chk("R10 win0", 4'd6, 32'h8020_5200);
        wr_reg(4'd2, 32'hFFFF);
        rd_chk("R10 types", 4'd2, 32'h1234);
        wr_reg(4'd3, 32'h0);
        rd_chk("R10 menu lo", 4'd3, 32'h0B03_0905);
        wr_reg(4'd4, 32'hFFFF_FFFF);
        rd_chk("R10 menu hi", 4'd4, 32'h0);
        wr_reg(4'd5, 32'h0);
        rd_chk("R10 prefix", 4'd5, 32'h0650);
        req("R10 still protects", 24'h20_0000, 1'b1, 1'b1);
        rd_chk("R10 blk set", 4'd0, 32'h0000_8008);
        wr_reg(4'd0, 32'h0000_0008);
        rd_chk("R10 w1c while locked", 4'd0, 32'h0000_8000);
    endtask

    task automatic t_relock_reset();
        do_reset();
        rd_chk("R9 reset clears lock", 4'd0, 32'h0);
        rd_chk("R1 win0 after reset", 4'd6, 32'h0);
        req("R1 open after reset", 24'h20_0000, 1'b1, 1'b0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        cfg_rsel = '0; req_valid = 1'b0; req_addr = '0; req_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fence();
        t_window();
        t_independent();
        t_lock();
        t_relock_reset();
        finish_run();
    end
endmodule